// File: doc/BRIEF.md
# Two-Partition State Machine Handoff

This block runs a single four-state control machine that has been split across two partitions, each able to hold only part of the machine. Partition 0 owns global states A and B, and partition 1 owns states C and D. At any moment exactly one partition is active and holds a real state. The other partition sits in a dedicated idle state of its own, called the parked state here.

Commands arrive on one input stream. Each command names the global state to go to next, and the active partition consumes it. A target inside the active partition is reached directly. A target in the other partition is instead encoded as a local index and placed on an activation token stream toward that partition. The token stays on the stream until the interconnect accepts it. In the cycle of acceptance, the sender parks and the receiver wakes directly in the named state. The two token streams are brought out to ports, so that the inter-partition interconnect, which may stall, sits outside the block.

Top module: `pfsm_pair`

## Requirements
- R1: After reset, partition 0 reports local state 0 (A), partition 1 reports the parked code 2, both token valids are low and cmd_ready is high.
- R2: In every cycle exactly one of p0_state and p1_state differs from the parked code 2.
- R3: An accepted command (cmd_valid and cmd_ready high at an edge) whose code names a state of the active partition sets that partition's state after the edge. The code is 0=A, 1=B, 2=C, 3=D: bit 1 selects the partition and bit 0 selects the local index. No token is raised.
- R4: An accepted command naming a state of the other partition raises that partition's incoming token valid after the edge, with the token target equal to bit 0 of the code. The sender's state is unchanged and cmd_ready drops.
- R5: While a token is valid and its ready is low, the token stays valid with an unchanged target, and both partition states hold.
- R6: At an edge where a token's valid and ready are both high, the sender moves to the parked code and the receiver moves to the token's target. The token valid then drops and cmd_ready rises.
- R7: Commands presented while a token is pending have no effect on either state, and a parked partition never takes a command.
- R8: A token ready that is high while its valid is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_next | input | 2 | Global code of the next state |
| tok01_valid | output | 1 | Activation token from partition 0 to partition 1 is valid |
| tok01_tgt | output | 1 | Local state index carried by that token |
| tok01_ready | input | 1 | Interconnect accepts the 0-to-1 token |
| tok10_valid | output | 1 | Activation token from partition 1 to partition 0 is valid |
| tok10_tgt | output | 1 | Local state index carried by that token |
| tok10_ready | input | 1 | Interconnect accepts the 1-to-0 token |
| p0_state | output | 2 | Partition 0 state: 0=A, 1=B, 2=parked |
| p1_state | output | 2 | Partition 1 state: 0=C, 1=D, 2=parked |

## Verification
The bench aims at long interconnect stalls with commands still arriving. A design that consumed those commands would jump state or overwrite the token target. It also drives handoffs in both directions to both local targets. A wrong sender or receiver update there would leave both partitions active, or both parked, for a cycle. Readies raised with no token pending are used to expose a wait state that wakes on ready alone. Local and cross commands are interleaved at random so that a swapped partition or index bit in the code decode shows up as a wrong state.

// File: rtl/pfsm_pkg.sv
package pfsm_pkg;
  // width helper that never yields zero
  function automatic int unsigned safe_clog2(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
  localparam int unsigned NUM_PARTS = 2;
endpackage

// File: rtl/pfsm_tok_slot.sv
module pfsm_tok_slot #(
  parameter int unsigned TW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] tgt_in,
  input  logic          drain_rdy,
  output logic          vld,
  output logic [TW-1:0] tgt
);
  logic          vld_d;
  logic          tgt_en;

  always_comb begin
    vld_d  = vld;
    tgt_en = load;
    if (vld && drain_rdy) vld_d = 1'b0;
    if (load)             vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      tgt <= '0;
    end else begin
      vld <= vld_d;
      if (tgt_en) tgt <= tgt_in;
    end
  end

  assert_tok_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !drain_rdy) |=> (vld && $stable(tgt)));
  assert_tok_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && drain_rdy && !load) |=> !vld);
endmodule

// File: rtl/pfsm_part.sv
module pfsm_part #(
  parameter int unsigned S   = 2,
  parameter int unsigned IDX = 0,
  parameter int unsigned GW  = 2,
  parameter int unsigned TW  = 1,
  parameter int unsigned SW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [GW-1:0] cmd_next,
  output logic          cmd_rdy,
  input  logic          in_fire,
  input  logic [TW-1:0] in_tgt,
  output logic          out_valid,
  output logic [TW-1:0] out_tgt,
  input  logic          out_ready,
  output logic [SW-1:0] state_o
);
  localparam logic [SW-1:0] PARKED   = SW'(S);
  localparam logic [SW-1:0] RESET_ST = (IDX == 0) ? '0 : PARKED;
  localparam logic [GW-1:0] S_G      = GW'(S);
  localparam logic [GW-1:0] IDX_G    = GW'(IDX);

  logic [SW-1:0] st_q, st_d;
  logic [GW-1:0] cmd_part, cmd_loc;
  logic          active, take, own, load;

  always_comb begin
    cmd_part = cmd_next / S_G;
    cmd_loc  = cmd_next % S_G;
    own      = (cmd_part == IDX_G);
    active   = (st_q != PARKED);
    cmd_rdy  = active && !out_valid;
    take     = cmd_valid && cmd_rdy;
    load     = take && !own;
  end

  pfsm_tok_slot #(.TW(TW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .tgt_in    (TW'(cmd_loc)),
    .drain_rdy (out_ready),
    .vld       (out_valid),
    .tgt       (out_tgt)
  );

  always_comb begin
    st_d = st_q;
    if (!active) begin
      if (in_fire) st_d = SW'(in_tgt);
    end else if (out_valid && out_ready) begin
      st_d = PARKED;
    end else if (take && own) begin
      st_d = SW'(cmd_loc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RESET_ST;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  assert_wake_only_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (st_q == PARKED));
  assert_local_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_rdy && (cmd_next / S_G) == IDX_G) |=>
      (st_q == SW'($past(cmd_next) % S_G)));
  assert_parked_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PARKED && !in_fire) |=> (st_q == PARKED));
  assert_sender_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (st_q == PARKED));
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(st_q));
endmodule

// File: rtl/pfsm_pair.sv
module pfsm_pair #(
  parameter int unsigned S  = 2,
  parameter int unsigned GW = pfsm_pkg::safe_clog2(2 * S),
  parameter int unsigned TW = pfsm_pkg::safe_clog2(S),
  parameter int unsigned SW = pfsm_pkg::safe_clog2(S + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [GW-1:0] cmd_next,
  output logic          tok01_valid,
  output logic [TW-1:0] tok01_tgt,
  input  logic          tok01_ready,
  output logic          tok10_valid,
  output logic [TW-1:0] tok10_tgt,
  input  logic          tok10_ready,
  output logic [SW-1:0] p0_state,
  output logic [SW-1:0] p1_state
);
  localparam int unsigned NP = pfsm_pkg::NUM_PARTS;
  localparam logic [SW-1:0] PARKED = SW'(S);

  logic          out_v  [NP];
  logic [TW-1:0] out_t  [NP];
  logic          out_r  [NP];
  logic          rdy    [NP];
  logic [SW-1:0] st     [NP];

  assign out_r[0] = tok01_ready;
  assign out_r[1] = tok10_ready;

  for (genvar p = 0; p < NP; p++) begin : g_part
    pfsm_part #(.S(S), .IDX(p), .GW(GW), .TW(TW), .SW(SW)) u_part (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_next  (cmd_next),
      .cmd_rdy   (rdy[p]),
      .in_fire   (out_v[NP-1-p] && out_r[NP-1-p]),
      .in_tgt    (out_t[NP-1-p]),
      .out_valid (out_v[p]),
      .out_tgt   (out_t[p]),
      .out_ready (out_r[p]),
      .state_o   (st[p])
    );
  end

  assign cmd_ready   = rdy[0] || rdy[1];
  assign tok01_valid = out_v[0];
  assign tok01_tgt   = out_t[0];
  assign tok10_valid = out_v[1];
  assign tok10_tgt   = out_t[1];
  assign p0_state    = st[0];
  assign p1_state    = st[1];

  assert_one_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({p0_state != PARKED, p1_state != PARKED}) == 1);
  assert_single_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok01_valid && tok10_valid));
  assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok01_valid && !tok10_valid && !cmd_valid) |=>
      ($stable(p0_state) && $stable(p1_state)));
endmodule

// File: tb/pfsm_pair_test.sv
module pfsm_pair_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [1:0] cmd_next;
  logic       tok01_valid, tok10_valid;
  logic       tok01_tgt, tok10_tgt;
  logic       tok01_ready, tok10_ready;
  logic [1:0] p0_state, p1_state;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int g_st;     // global state 0..3
  bit pend;
  int ptgt;

  pfsm_pair uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_next(cmd_next), .tok01_valid(tok01_valid), .tok01_tgt(tok01_tgt),
    .tok01_ready(tok01_ready), .tok10_valid(tok10_valid), .tok10_tgt(tok10_tgt),
    .tok10_ready(tok10_ready), .p0_state(p0_state), .p1_state(p1_state)
  );

  always #5 clk = ~clk;

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_pst(int part);
    return (g_st / 2 == part) ? g_st % 2 : 2;
  endfunction

  task automatic check_all(string tag);
    int act = g_st / 2;
    chk({tag, " R3/R6 p0_state"}, p0_state, exp_pst(0));
    chk({tag, " R3/R6 p1_state"}, p1_state, exp_pst(1));
    chk({tag, " R2 one active"}, int'(p0_state != 2) + int'(p1_state != 2), 1);
    chk({tag, " R4/R5 tok01_valid"}, tok01_valid, int'(pend && act == 0));
    chk({tag, " R4/R5 tok10_valid"}, tok10_valid, int'(pend && act == 1));
    if (pend && act == 0) chk({tag, " R5 tok01_tgt"}, tok01_tgt, ptgt);
    if (pend && act == 1) chk({tag, " R5 tok10_tgt"}, tok10_tgt, ptgt);
    chk({tag, " R7 cmd_ready"}, cmd_ready, int'(!pend));
  endtask

  // model step for the coming edge, using the applied inputs
  task automatic model_step();
    int act = g_st / 2;
    if (pend) begin
      if ((act == 0 && tok01_ready) || (act == 1 && tok10_ready)) begin
        g_st = (1 - act) * 2 + ptgt;
        pend = 0;
      end
    end else if (cmd_valid) begin
      if (int'(cmd_next) / 2 == act) g_st = int'(cmd_next);
      else begin
        pend = 1;
        ptgt = int'(cmd_next) % 2;
      end
    end
  endtask

  task automatic apply(bit v, int nx, bit r01, bit r10, string tag);
    cmd_valid   = v;
    cmd_next    = 2'(nx);
    tok01_ready = r01;
    tok10_ready = r10;
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cmd_valid = 0; cmd_next = 0; tok01_ready = 0; tok10_ready = 0;
    g_st = 0; pend = 0; ptgt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 p0_state", p0_state, 0);
    chk("R1 p1_state", p1_state, 2);
    chk("R1 tok01_valid", tok01_valid, 0);
    chk("R1 tok10_valid", tok10_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 idle");

    // R8 readies with no token
    apply(0, 0, 1, 1, "R8 idle ready");
    apply(0, 0, 1, 1, "R8 idle ready");
    // R3 local move A->B
    apply(1, 1, 0, 0, "R3 local");
    // R4 cross to D, then long stall with commands (R5, R7)
    apply(1, 3, 0, 0, "R4 cross");
    for (int i = 0; i < 5; i++) apply(1, i % 4, 0, 1, "R5/R7 stall");
    // R6 handoff 0->1
    apply(0, 0, 1, 0, "R6 handoff");
    // back to A via 1->0 with stall
    apply(1, 0, 0, 0, "R4 back");
    apply(1, 2, 1, 0, "R5 wrong ready");
    apply(0, 0, 0, 1, "R6 back");

    for (int i = 0; i < 4000; i++) begin
      bit v   = ($urandom % 4) != 0;
      int nx  = $urandom % 4;
      bit r01 = ($urandom % 3) == 0;
      bit r10 = ($urandom % 3) == 0;
      apply(v, nx, r01, r10, "rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule